// File: doc/BRIEF.md
# Low-Power Mode Control Unit

This block decides what the processor's halt instruction does. It holds an 8-bit control register with two writable bits. One bit picks a light sleep or a deep standby. The other picks whether the I/O pins float or keep their levels while in standby.

A one-cycle sleep-request strobe from the CPU starts the transition. In sleep, the CPU is halted but the peripheral clock keeps running. In standby, all clocks stop and the pins are parked.

Sleep ends on any enabled interrupt or on the non-maskable interrupt (NMI). Standby ends only on the NMI, and then only after a fixed oscillator-settling wait. A reset ends either state.

A running watchdog blocks any write that would set either mode bit. Writes that clear the mode bits are always accepted.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the register reads 0x1F and the status is 2'b00 (run). In that state `cpu_halt` is 0, `periph_clk_en` is 1, `sys_clk_stop` is 0, and every `pin_hiz`/`pin_hold` bit is 0.
- R2: With `wdt_en` at 0, a write stores data bit 7 (mode select: 0 sleep, 1 standby) and bit 6 (pin mode: 0 hold, 1 high-impedance), visible on the next read. Bit 5 always reads 0 and bits 4..0 always read 1, whatever is written.
- R3: With `wdt_en` at 1, writing a 1 to bit 7 or bit 6 leaves that bit unchanged. Writing a 0 to it clears it.
- R4: With bit 7 at 0, a sleep request in run raises `cpu_halt` in the same cycle, and the status becomes 2'b01 on the next edge. While in sleep, `cpu_halt` is 1, `periph_clk_en` is 1 and `sys_clk_stop` is 0.
- R5: In sleep, `irq_wake` or `nmi` returns the status to 2'b00 on the next edge. `cpu_halt` then falls.
- R6: With bit 7 at 1, a sleep request in run makes the status 2'b10 on the next edge. In standby, `cpu_halt` is 0, `periph_clk_en` is 0 and `sys_clk_stop` is 1. `irq_wake` does not leave standby.
- R7: In standby and in the settling wait, every pin output follows bit 6. With bit 6 at 1, every `pin_hiz` bit is 1 and every `pin_hold` bit is 0; with bit 6 at 0, the reverse. In run and sleep, both vectors are all zero.
- R8: `nmi` in standby moves the status to 2'b11 for exactly SETTLE_CYC cycles, then to 2'b00. During the wait, the clocks stay stopped as in standby.
- R9: A sleep request while in sleep, standby or the settling wait has no effect on the status or the outputs.
- R10: An asynchronous reset from any state returns the status to 2'b00 and clears bits 7 and 6 immediately, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| wdt_en | input | 1 | Watchdog running; blocks setting the mode bits |
| halt_req | input | 1 | Sleep-request strobe from the CPU |
| irq_wake | input | 1 | An enabled interrupt is pending |
| nmi | input | 1 | Non-maskable interrupt |
| cpu_halt | output | 1 | Halts the CPU |
| periph_clk_en | output | 1 | Peripheral clock enable |
| sys_clk_stop | output | 1 | Stops the system clock |
| pin_hiz | output | NPORTS | Per-port high-impedance control |
| pin_hold | output | NPORTS | Per-port level-hold control |
| state_o | output | 2 | 00 run, 01 sleep, 10 standby, 11 settling |

## Verification
The bench builds the block with SETTLE_CYC = 5 and NPORTS = 3. With the short wait, a full standby, settle and run round trip fits into a few cycles, so random stimulus reaches the wait often and checks its exact length many times. Three ports keep the replicated pin vectors wide enough that a single wrong bit would show up in the compare.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NPORTS     = 4,
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              wdt_en,
  input  logic              halt_req,
  input  logic              irq_wake,
  input  logic              nmi,
  output logic              cpu_halt,
  output logic              periph_clk_en,
  output logic              sys_clk_stop,
  output logic [NPORTS-1:0] pin_hiz,
  output logic [NPORTS-1:0] pin_hold,
  output logic [1:0]        state_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [1:0] ST_RUN = 2'b00, ST_SLP = 2'b01, ST_SBY = 2'b10, ST_SET = 2'b11;
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

  logic [1:0]    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mode_q, hiz_q;
  logic          parked;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      hiz_q  <= 1'b0;
    end else if (reg_we) begin
      mode_q <= wdt_en ? (mode_q & reg_wdata[7]) : reg_wdata[7];
      hiz_q  <= wdt_en ? (hiz_q  & reg_wdata[6]) : reg_wdata[6];
    end
  end

  assign reg_rdata = {mode_q, hiz_q, 6'b01_1111};

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_RUN: if (halt_req) st_d = mode_q ? ST_SBY : ST_SLP;
      ST_SLP: if (irq_wake || nmi) st_d = ST_RUN;
      ST_SBY: if (nmi) begin
                st_d  = ST_SET;
                cnt_d = '0;
              end
      default: begin
                if (cnt_q == CNT_LAST) st_d = ST_RUN;
                else cnt_d = cnt_q + 1'b1;
              end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign parked        = st_q[1];
  assign state_o       = st_q;
  assign cpu_halt      = (st_q == ST_SLP) || (st_q == ST_RUN && halt_req && !mode_q);
  assign periph_clk_en = !parked;
  assign sys_clk_stop  = parked;
  assign pin_hiz       = {NPORTS{parked &  hiz_q}};
  assign pin_hold      = {NPORTS{parked & ~hiz_q}};

  assert_ro_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5:0] == 6'h1F);

  assert_wdt_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && wdt_en && !reg_rdata[7]) |=> !reg_rdata[7]);

  assert_sleep_outs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SLP) |-> (cpu_halt && periph_clk_en && !sys_clk_stop));

  assert_sleep_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SLP && (irq_wake || nmi)) |=> (state_o == ST_RUN));

  assert_stby_outs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SBY) |-> (!cpu_halt && !periph_clk_en && sys_clk_stop));

  assert_pins_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_hiz & pin_hold) == '0) && (periph_clk_en -> (pin_hiz == '0 && pin_hold == '0)));

  assert_settle_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SET) |-> (cnt_q < CW'(SETTLE_CYC)));

  assert_stby_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SBY && !nmi) |=> (state_o == ST_SBY));
endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam int NP = 3;
  localparam int SC = 5;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, wdt_en = 0, halt_req = 0, irq_wake = 0, nmi = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cpu_halt, periph_clk_en, sys_clk_stop;
  logic [NP-1:0] pin_hiz, pin_hold;
  logic [1:0] state_o;

  int n_chk = 0, n_fail = 0;
  logic [1:0] m_st; logic m_mode, m_hiz; int m_cnt;

  lpm_ctrl #(.NPORTS(NP), .SETTLE_CYC(SC)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdt_en(wdt_en), .halt_req(halt_req), .irq_wake(irq_wake), .nmi(nmi),
    .cpu_halt(cpu_halt), .periph_clk_en(periph_clk_en), .sys_clk_stop(sys_clk_stop),
    .pin_hiz(pin_hiz), .pin_hold(pin_hold), .state_o(state_o));

  always #2 clk = ~clk;

  function automatic logic [7:0] f_rd(logic md, logic hz);
    return {md, hz, 6'h1F};
  endfunction
  function automatic logic f_halt(logic [1:0] s, logic md, logic hr);
    return (s == 2'b01) || (s == 2'b00 && hr && !md);
  endfunction

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic pk;
    pk = m_st[1];
    case (m_st)
      2'b00: chk(state_o == m_st, "R5 state", state_o, m_st);
      2'b01: chk(state_o == m_st, "R4 state", state_o, m_st);
      2'b10: chk(state_o == m_st, "R6 state", state_o, m_st);
      default: chk(state_o == m_st, "R8 state", state_o, m_st);
    endcase
    chk(reg_rdata == f_rd(m_mode, m_hiz), wdt_en ? "R3 rdata" : "R2 rdata", reg_rdata, f_rd(m_mode, m_hiz));
    chk(cpu_halt == f_halt(m_st, m_mode, halt_req), "R4 cpu_halt", cpu_halt, f_halt(m_st, m_mode, halt_req));
    chk({periph_clk_en, sys_clk_stop} == {!pk, pk}, "R6 clocks", {periph_clk_en, sys_clk_stop}, {!pk, pk});
    chk(pin_hiz == {NP{pk & m_hiz}} && pin_hold == {NP{pk & !m_hiz}}, "R7 pins",
        {pin_hiz, pin_hold}, {{NP{pk & m_hiz}}, {NP{pk & !m_hiz}}});
  endtask

  task automatic tick();
    logic [1:0] ns; int nc; logic nm, nh;
    ns = m_st; nc = m_cnt; nm = m_mode; nh = m_hiz;
    if (reg_we) begin
      nm = wdt_en ? (m_mode & reg_wdata[7]) : reg_wdata[7];
      nh = wdt_en ? (m_hiz & reg_wdata[6]) : reg_wdata[6];
    end
    case (m_st)
      2'b00: if (halt_req) ns = m_mode ? 2'b10 : 2'b01;
      2'b01: if (irq_wake || nmi) ns = 2'b00;
      2'b10: if (nmi) begin ns = 2'b11; nc = 0; end
      default: if (m_cnt == SC - 1) ns = 2'b00; else nc = m_cnt + 1;
    endcase
    @(posedge clk); #1;
    m_st = ns; m_cnt = nc; m_mode = nm; m_hiz = nh;
    check_all();
  endtask

  task automatic drive(logic we, logic [7:0] wd, logic wdt, logic hr, logic ir, logic nm);
    reg_we = we; reg_wdata = wd; wdt_en = wdt; halt_req = hr; irq_wake = ir; nmi = nm;
  endtask

  task automatic idle(); drive(0, 8'h00, wdt_en, 0, 0, 0); endtask

  task automatic model_reset(); m_st = 0; m_cnt = 0; m_mode = 0; m_hiz = 0; endtask

  initial begin
    int unsigned sd;
    int n_set;
    sd = $urandom(32'd4242);
    model_reset();
    #1;
    chk(reg_rdata == 8'h1F && state_o == 2'b00, "R1 in reset", {reg_rdata, state_o}, {8'h1F, 2'b00});
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    check_all();
    chk(periph_clk_en && !sys_clk_stop && !cpu_halt && pin_hiz == 0 && pin_hold == 0, "R1 outputs",
        {periph_clk_en, sys_clk_stop, cpu_halt}, 3'b100);

    drive(1, 8'hFF, 0, 0, 0, 0); tick();
    chk(reg_rdata == 8'hDF, "R2 write all ones", reg_rdata, 8'hDF);
    drive(1, 8'h3F, 1, 0, 0, 0); tick();
    chk(reg_rdata == 8'h1F, "R3 clear under wdt", reg_rdata, 8'h1F);
    drive(1, 8'hC0, 1, 0, 0, 0); tick();
    chk(reg_rdata == 8'h1F, "R3 set blocked", reg_rdata, 8'h1F);
    drive(0, 8'h00, 0, 1, 0, 0); #1;
    chk(cpu_halt == 1'b1, "R4 halt at once", cpu_halt, 1);
    tick(); idle();
    chk(state_o == 2'b01, "R4 sleep entered", state_o, 2'b01);
    drive(1, 8'h80, 0, 1, 0, 0); tick();
    chk(state_o == 2'b01 && cpu_halt && periph_clk_en, "R9 request in sleep", state_o, 2'b01);
    drive(0, 8'h00, 0, 0, 1, 0); tick(); idle();
    chk(state_o == 2'b00 && !cpu_halt, "R5 irq exits sleep", state_o, 2'b00);

    drive(1, 8'hC0, 0, 0, 0, 0); tick();
    drive(0, 8'h00, 0, 1, 0, 0); tick(); idle();
    chk(state_o == 2'b10 && sys_clk_stop && !cpu_halt, "R6 standby entered", state_o, 2'b10);
    chk(pin_hiz == '1 && pin_hold == '0, "R7 hiz pins", {pin_hiz, pin_hold}, {{NP{1'b1}}, {NP{1'b0}}});
    drive(0, 8'h00, 0, 1, 1, 0); tick();
    chk(state_o == 2'b10, "R9 R6 request and irq in standby", state_o, 2'b10);
    drive(0, 8'h00, 0, 0, 0, 1); tick(); idle();
    n_set = 0;
    while (state_o == 2'b11 && n_set < 50) begin
      chk(sys_clk_stop && !periph_clk_en, "R8 clocks held", sys_clk_stop, 1);
      n_set++;
      if (n_set == 2) halt_req = 1;
      tick();
      halt_req = 0;
    end
    chk(n_set == SC, "R8 settle length", n_set, SC);
    chk(state_o == 2'b00, "R8 back to run", state_o, 2'b00);

    drive(1, 8'h80, 0, 0, 0, 0); tick();
    drive(0, 8'h00, 0, 1, 0, 0); tick(); idle();
    chk(pin_hold == '1 && pin_hiz == '0, "R7 hold pins", {pin_hiz, pin_hold}, {{NP{1'b0}}, {NP{1'b1}}});
    #1 rst_n = 0; #1;
    chk(state_o == 2'b00 && reg_rdata == 8'h1F, "R10 async reset", {reg_rdata, state_o}, {8'h1F, 2'b00});
    model_reset();
    @(posedge clk); #1 rst_n = 1;
    check_all();

    for (int i = 0; i < 600; i++) begin
      drive(($urandom % 6) == 0, 8'($urandom), ($urandom % 3) == 0, ($urandom % 4) == 0,
            ($urandom % 8) == 0, ($urandom % 12) == 0);
      tick();
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hang exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule